// File: doc/BRIEF.md
# Dual-clock BCD up/down counter

This block is one decimal digit, 0 to 9, that is moved by two separate count lines. A rising edge on the up line adds one and a rising edge on the down line subtracts one. The digit wraps at both ends. If a code from 10 to 15 has been forced in, the next step brings the digit back into the decimal range. Two active-low strobes report the ends of the range and can clock a neighbouring digit. The carry strobe is low while the digit is 9 and the up line is low. The borrow strobe is low while the digit is 0 and the down line is low. Each strobe returns high as soon as its count line rises again.

The block runs on a fast system clock. Each count line passes through a synchronizer, and the block detects its rising edge internally. The digit register has two asynchronous overrides. A high master clear sets the digit to 0 and wins over everything else. A low preset line copies the 4-bit preset value into the digit. A separate synchronous system reset, active high, puts the synchronizers into their idle-high state and clears the digit.

Top module: `bcd_updown_digit`

## Requirements
- R1: A rising edge on `up_clk_in`, with `dn_clk_in` held high, adds one to `digit`. The change appears at the third rising `clk` edge after the input rises, and the step is applied exactly once.
- R2: A rising edge on `dn_clk_in`, with `up_clk_in` held high, subtracts one from `digit`, with the same latency as R1.
- R3: Counting up from 9 gives 0, and counting down from 0 gives 9.
- R4: If `digit` holds 10 to 15, an up step gives 0 and a down step gives 9.
- R5: If rising edges of both count lines are seen in the same system cycle, `digit` holds. Without a rising edge, `digit` holds.
- R6: `carry_n` is 0 exactly when `digit` is 9 and `up_clk_in` is 0. It is 1 otherwise and follows the inputs without a clock.
- R7: `borrow_n` is 0 exactly when `digit` is 0 and `dn_clk_in` is 0. It is 1 otherwise and follows the inputs without a clock.
- R8: A falling `load_n` copies `preset` into `digit` at once, without a clock. While `load_n` stays 0, `digit` takes the present `preset` at every `clk` edge.
- R9: While `mst_clr` is 1, `digit` is 0 at once, whatever `load_n` and the count lines do.
- R10: While `rst` is 1 at a `clk` edge, `digit` is cleared and the synchronizers go idle high. Releasing `rst` with both count lines high causes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous system reset, active high |
| up_clk_in | input | 1 | Count-up line, counts on its rising edge |
| dn_clk_in | input | 1 | Count-down line, counts on its rising edge |
| load_n | input | 1 | Asynchronous preset, active low |
| mst_clr | input | 1 | Asynchronous master clear, active high |
| preset | input | 4 | Value copied by the preset |
| digit | output | 4 | Current count |
| carry_n | output | 1 | Terminal-count-up strobe, active low |
| borrow_n | output | 1 | Terminal-count-down strobe, active low |

## Verification
The step assertions assume three things about the inputs. The count lines change slowly compared with `clk`. The asynchronous overrides are idle over the cycle being checked. The two lines rise together only when a hold is intended. The stimulus holds each count line at a level for at least three system cycles. It drives the overrides only between count pulses, and pulls both lines low together only in the deliberate simultaneous-edge case. The bench sweeps all sixteen preset codes and checks both directions and both strobes for every code.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_t;

  localparam int unsigned LINES = 2;
  localparam int unsigned LINE_UP = 0;
  localparam int unsigned LINE_DN = 1;
endpackage

// File: rtl/line_edge_sync.sv
module line_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic level,
  output logic rise
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '1;
    else     shreg <= {shreg[LAST-1:0], line_in};
  end

  assign level = shreg[LAST-1];
  assign rise  = shreg[LAST-1] & ~shreg[LAST];

  // a detected edge never repeats on the following cycle (one step per edge)
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/bcd_step.sv
module bcd_step
  import bcd_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4,
  parameter int unsigned TOP_VAL = 9
) (
  input  logic [DIGIT_W-1:0] cur,
  input  logic               up_rise,
  input  logic               dn_rise,
  output logic [DIGIT_W-1:0] nxt,
  output step_t              kind
);
  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(TOP_VAL);

  always_comb begin
    kind = STEP_HOLD;
    if (up_rise && !dn_rise) kind = STEP_UP;
    else if (dn_rise && !up_rise) kind = STEP_DN;
  end

  always_comb begin
    unique case (kind)
      STEP_UP: nxt = (cur >= TOP) ? '0 : cur + 1'b1;
      STEP_DN: nxt = (cur == '0 || cur > TOP) ? TOP : cur - 1'b1;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/term_strobe.sv
module term_strobe #(
  parameter int unsigned DIGIT_W = 4,
  parameter int unsigned TOP_VAL = 9
) (
  input  logic [DIGIT_W-1:0] digit,
  input  logic               up_line,
  input  logic               dn_line,
  output logic               carry_n,
  output logic               borrow_n
);
  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(TOP_VAL);

  assign carry_n  = ~((digit == TOP) & ~up_line);
  assign borrow_n = ~((digit == '0)  & ~dn_line);
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit
  import bcd_pkg::*;
#(
  parameter int unsigned DIGIT_W     = 4,
  parameter int unsigned TOP_VAL     = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_clk_in,
  input  logic               dn_clk_in,
  input  logic               load_n,
  input  logic               mst_clr,
  input  logic [DIGIT_W-1:0] preset,
  output logic [DIGIT_W-1:0] digit,
  output logic               carry_n,
  output logic               borrow_n
);
  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(TOP_VAL);

  logic [LINES-1:0] raw_line;
  logic [LINES-1:0] sync_lvl;
  logic [LINES-1:0] sync_rise;
  logic [DIGIT_W-1:0] digit_q;
  logic [DIGIT_W-1:0] digit_d;
  step_t step_kind;

  assign raw_line[LINE_UP] = up_clk_in;
  assign raw_line[LINE_DN] = dn_clk_in;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .line_in(raw_line[g]),
      .level  (sync_lvl[g]),
      .rise   (sync_rise[g])
    );
  end

  bcd_step #(.DIGIT_W(DIGIT_W), .TOP_VAL(TOP_VAL)) u_step (
    .cur    (digit_q),
    .up_rise(sync_rise[LINE_UP]),
    .dn_rise(sync_rise[LINE_DN]),
    .nxt    (digit_d),
    .kind   (step_kind)
  );

  always_ff @(posedge clk or posedge mst_clr or negedge load_n) begin
    if (mst_clr)      digit_q <= '0;
    else if (!load_n) digit_q <= preset;
    else if (rst)     digit_q <= '0;
    else              digit_q <= digit_d;
  end

  term_strobe #(.DIGIT_W(DIGIT_W), .TOP_VAL(TOP_VAL)) u_term (
    .digit   (digit_q),
    .up_line (up_clk_in),
    .dn_line (dn_clk_in),
    .carry_n (carry_n),
    .borrow_n(borrow_n)
  );

  assign digit = digit_q;

  // step results relate detected edges to the register a cycle later
  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst || mst_clr || !load_n)
    (sync_rise[LINE_UP] && !sync_rise[LINE_DN] && digit_q == TOP) |=> digit_q == '0);
  assert_dn_wrap_R3: assert property (@(posedge clk) disable iff (rst || mst_clr || !load_n)
    (sync_rise[LINE_DN] && !sync_rise[LINE_UP] && digit_q == '0) |=> digit_q == TOP);
  assert_back_in_range_R4: assert property (@(posedge clk) disable iff (rst || mst_clr || !load_n)
    (sync_rise[LINE_UP] ^ sync_rise[LINE_DN]) |=> digit_q <= TOP);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst || mst_clr || !load_n)
    (sync_rise[LINE_UP] == sync_rise[LINE_DN]) |=> $stable(digit_q));
  assert_carry_only_at_top_R6: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (digit_q == TOP && !up_clk_in));
  assert_borrow_only_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (digit_q == '0 && !dn_clk_in));
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    mst_clr |-> digit_q == '0);
  assert_idle_after_reset_R10: assert property (@(posedge clk)
    rst |=> (sync_lvl == '1 && sync_rise == '0));
endmodule

// File: tb/sim_bcd_updown_digit.sv
`timescale 1ns/1ps
module sim_bcd_updown_digit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_clk_in = 1'b1;
  logic dn_clk_in = 1'b1;
  logic load_n = 1'b1;
  logic mst_clr = 1'b0;
  logic [3:0] preset = 4'd0;
  logic [3:0] digit;
  logic carry_n, borrow_n;

  int n_chk = 0;
  int n_fail = 0;
  int model = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_updown_digit u0 (
    .clk(clk), .rst(rst), .up_clk_in(up_clk_in), .dn_clk_in(dn_clk_in),
    .load_n(load_n), .mst_clr(mst_clr), .preset(preset),
    .digit(digit), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int up_of(input int v);
    return (v >= 9) ? 0 : v + 1;
  endfunction

  function automatic int dn_of(input int v);
    return (v == 0 || v > 9) ? 9 : v - 1;
  endfunction

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_val(input int v);
    @(negedge clk);
    preset = 4'(v);
    load_n = 1'b0;
    #1 chk("R8 async load", digit, v);
    @(negedge clk);
    load_n = 1'b1;
    model = v;
  endtask

  task automatic pulse_up(input string req);
    @(negedge clk);
    up_clk_in = 1'b0;
    #1 chk("R6 carry low phase", carry_n, (model == 9) ? 0 : 1);
    wait_clk(3);
    up_clk_in = 1'b1;
    #1 chk("R6 carry released", carry_n, 1);
    wait_clk(4);
    model = up_of(model);
    chk(req, digit, model);
  endtask

  task automatic pulse_dn(input string req);
    @(negedge clk);
    dn_clk_in = 1'b0;
    #1 chk("R7 borrow low phase", borrow_n, (model == 0) ? 0 : 1);
    wait_clk(3);
    dn_clk_in = 1'b1;
    #1 chk("R7 borrow released", borrow_n, 1);
    wait_clk(4);
    model = dn_of(model);
    chk(req, digit, model);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst = 1'b0;
    chk("R10 reset value", digit, 0);
    chk("R6 carry idle", carry_n, 1);
    chk("R7 borrow idle", borrow_n, 1);
    wait_clk(5);
    chk("R10 no step after release", digit, 0);

    // sweep every code in both directions (R1 R2 R3 R4)
    for (int v = 0; v < 16; v++) begin
      load_val(v);
      pulse_up((v >= 9) ? "R3/R4 up from edge code" : "R1 up step");
      load_val(v);
      pulse_dn((v == 0 || v > 9) ? "R3/R4 down from edge code" : "R2 down step");
    end

    // long runs around the ring
    load_val(0);
    for (int i = 0; i < 23; i++) pulse_up("R1 run up");
    for (int i = 0; i < 23; i++) pulse_dn("R2 run down");

    // simultaneous edges hold (R5)
    load_val(5);
    @(negedge clk);
    up_clk_in = 1'b0;
    dn_clk_in = 1'b0;
    wait_clk(3);
    up_clk_in = 1'b1;
    dn_clk_in = 1'b1;
    wait_clk(4);
    chk("R5 both edges hold", digit, 5);
    wait_clk(6);
    chk("R5 idle hold", digit, 5);

    // clear over load (R9), then load tracking while held (R8)
    @(negedge clk);
    preset = 4'd7;
    load_n = 1'b0;
    #1 mst_clr = 1'b1;
    #1 chk("R9 clear wins over load", digit, 0);
    wait_clk(2);
    chk("R9 clear held", digit, 0);
    mst_clr = 1'b0;
    wait_clk(1);
    chk("R8 load after clear", digit, 7);
    preset = 4'd3;
    wait_clk(1);
    chk("R8 load tracks preset", digit, 3);
    load_n = 1'b1;
    model = 3;
    wait_clk(3);
    chk("R8 value kept after load", digit, 3);

    // synchronous reset clears the digit (R10)
    @(negedge clk);
    rst = 1'b1;
    wait_clk(1);
    chk("R10 sync clear", digit, 0);
    rst = 1'b0;
    model = 0;
    pulse_dn("R10 count after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule